// File: doc/BRIEF.md
# Panel Register Write Serializer

This block turns a single register-write request into the two serial transactions that an LCD panel controller expects on its configuration port. A request carries an 8-bit index field, of which only the low seven bits are used, and a 16-bit value. The block first sends an index frame and then a data frame. Each frame is a separate 24-bit transfer framed by an active-low chip select, and the two frames are separated by a short idle gap. Each frame starts with an opcode byte that tells the panel how to interpret the two bytes that follow.

The serial port runs in SPI mode 3. The clock idles high, MOSI moves on falling edges and the panel samples it on rising edges. The clock half-period is a parameter counted in system clock cycles; the default gives roughly 800 kHz from a 200 MHz system clock. A sequencer drives `start_i` for one cycle and waits for `done_o`. While the block is working it reports `busy_o`. The sequencer may cancel a write with `abort_i`, which returns the lines to idle and is acknowledged with `aborted_o` instead of `done_o`.

Top module: `panel_reg_writer`

## Requirements
- R1: The first frame of a write carries the bytes 0x74, 0x00 and then the request index with bit 7 forced to 0.
- R2: The second frame carries the bytes 0x76, then the value's bits 15..8, then its bits 7..0.
- R3: Each frame is exactly 24 bits inside one low period of `cs_n_o`, most significant bit first.
- R4: The bus follows SPI mode 3: `sclk_o` is high whenever `cs_n_o` is high, and while `cs_n_o` stays low, `mosi_o` changes only in the cycle where `sclk_o` falls.
- R5: Between the index frame and the data frame, `cs_n_o` stays high for at least 2*HALF_DIV system clock cycles, which is one full serial clock period.
- R6: `busy_o` is high from the cycle after a start is accepted until the write ends. `done_o` is a one-cycle pulse after the data frame, and `busy_o` is low in that cycle.
- R7: A start request seen while `busy_o` is high is ignored: it changes neither frame and does not trigger a later transfer.
- R8: An abort while busy makes the next cycle show `cs_n_o`=1, `sclk_o`=1, `busy_o`=0 and a one-cycle `aborted_o` pulse, and no `done_o` follows.
- R9: After reset, `cs_n_o`=1, `sclk_o`=1 and `busy_o`, `done_o` and `aborted_o` are 0.
- R10: Inside a frame, every low phase of `sclk_o` lasts exactly HALF_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to write a register |
| reg_idx_i | input | 8 | Register index; bit 7 is discarded |
| reg_val_i | input | 16 | Value to write |
| abort_i | input | 1 | Cancel the write in progress |
| busy_o | output | 1 | A write is in progress |
| done_o | output | 1 | One-cycle pulse when a write completes |
| aborted_o | output | 1 | One-cycle pulse when a write was cancelled |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the panel |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
Writes are issued with all-zero index and value, all-one index and value, alternating bit patterns, and an index with bit 7 set. The all-zero and all-one cases expose stuck or shifted bits. The alternating patterns expose byte swaps and bit-order errors, and the bit-7 case exposes a missing mask. A start pulse injected in the middle of a write shows whether the block queues or latches new data while busy. An abort issued partway through a frame, followed by a clean write, shows whether the block recovers to idle without a stray completion. A decoder in the bench watches every clock for chip-select gaps, clock idle level, the low-phase width and MOSI edge placement.

// File: rtl/panel_reg_writer.sv
module panel_reg_writer #(
  parameter int HALF_DIV = 125,
  parameter logic [7:0] IDX_OPC = 8'h74,
  parameter logic [7:0] DAT_OPC = 8'h76
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  reg_idx_i,
  input  logic [15:0] reg_val_i,
  input  logic        abort_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        aborted_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_n_o
);
  localparam int FRAME_BITS = 24;
  localparam int LAST_H = 2 * FRAME_BITS;
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam int HW = $clog2(LAST_H + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [HW-1:0]        h;
  logic [FRAME_BITS-1:0] sh;
  logic [15:0]          val_q;
  logic                 second, gapn;
  logic                 sclk_q, cs_q, done_q, abort_q;
  logic                 tick;

  assign tick      = (cnt == CW'(HALF_DIV - 1));
  assign busy_o    = (st != S_IDLE);
  assign done_o    = done_q;
  assign aborted_o = abort_q;
  assign sclk_o    = sclk_q;
  assign cs_n_o    = cs_q;
  assign mosi_o    = sh[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      h <= '0;
      sh <= '0;
      val_q <= '0;
      second <= 1'b0;
      gapn <= 1'b0;
      sclk_q <= 1'b1;
      cs_q <= 1'b1;
      done_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      abort_q <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0;
        if (start_i) begin
          sh <= {IDX_OPC, 8'h00, 1'b0, reg_idx_i[6:0]};
          val_q <= reg_val_i;
          second <= 1'b0;
          h <= '0;
          cs_q <= 1'b0;
          st <= S_XFER;
        end
      end else if (abort_i) begin
        st <= S_IDLE;
        cs_q <= 1'b1;
        sclk_q <= 1'b1;
        abort_q <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          if (st == S_XFER) begin
            if (h == HW'(LAST_H)) begin
              cs_q <= 1'b1;
              gapn <= 1'b0;
              st <= S_GAP;
            end else begin
              h <= h + 1'b1;
              sclk_q <= h[0];
              if (!h[0] && h != '0) sh <= {sh[FRAME_BITS-2:0], 1'b0};
            end
          end else begin
            if (!gapn) begin
              gapn <= 1'b1;
            end else if (!second) begin
              sh <= {DAT_OPC, val_q};
              second <= 1'b1;
              h <= '0;
              cs_q <= 1'b0;
              st <= S_XFER;
            end else begin
              st <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R4
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o) && !($past(sclk_o) && !sclk_o)) |-> $stable(mosi_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !abort_i) |=> $stable(val_q));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i) |=> (cs_n_o && sclk_o && aborted_o && !busy_o && !done_o));
endmodule

// File: tb/panel_reg_writer_tb_top.sv
module panel_reg_writer_tb_top;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [7:0] idx = '0;
  logic [15:0] val = '0;
  logic busy, done, aborted, sclk, mosi, cs_n;

  int checks = 0, errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  panel_reg_writer #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .reg_idx_i(idx), .reg_val_i(val),
    .abort_i(abort), .busy_o(busy), .done_o(done), .aborted_o(aborted),
    .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [23:0] fq[$];
  int bq[$];
  int gq[$];
  logic p_cs, p_sclk, p_mosi;
  logic [23:0] acc;
  int acc_bits, lowcnt, gapcnt;
  bit done_seen;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_cs = 1; p_sclk = 1; p_mosi = 0; acc = 0; acc_bits = 0; lowcnt = 0; gapcnt = 0;
    end else begin
      if (done) done_seen = 1;
      if (cs_n) chk(sclk === 1'b1, "R4 clock idles high", sclk, 1);
      if (!cs_n && !p_cs && mosi !== p_mosi)
        chk(p_sclk && !sclk, "R4 mosi moves on falling edge", {p_sclk, sclk}, 2'b10);
      if (!sclk) lowcnt++;
      else if (!p_sclk) begin
        if (!cs_n) chk(lowcnt == HALF, "R10 low phase width", lowcnt, HALF);
        lowcnt = 0;
      end
      if (sclk && !p_sclk && !cs_n) begin
        acc = {acc[22:0], mosi};
        acc_bits++;
      end
      if (!cs_n && p_cs) begin
        gq.push_back(gapcnt);
        gapcnt = 0; acc = 0; acc_bits = 0;
      end
      if (cs_n && !p_cs) begin
        fq.push_back(acc);
        bq.push_back(acc_bits);
      end
      if (cs_n) gapcnt++;
      p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
    end
  end

  task automatic do_write(input logic [7:0] i, input logic [15:0] v, input bit inject, input int inj_at);
    int n;
    logic [23:0] f;
    int g;
    fq.delete(); bq.delete(); gq.delete();
    @(negedge clk);
    idx = i; val = v; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 2000) begin
      if (inject && n == inj_at) begin
        idx = ~i; val = ~v; start = 1;
      end else begin
        start = 0;
      end
      chk(busy === 1'b1, "R6 busy during write", busy, 1);
      @(negedge clk);
      n++;
    end
    start = 0;
    chk(done === 1'b1, "R6 done reached", done, 1);
    chk(busy === 1'b0, "R6 busy low with done", busy, 0);
    chk(fq.size() == 2, "R3 two frames", fq.size(), 2);
    if (fq.size() == 2) begin
      f = fq[0];
      chk(f == {8'h74, 8'h00, 1'b0, i[6:0]}, "R1 index frame", f, {8'h74, 8'h00, 1'b0, i[6:0]});
      f = fq[1];
      chk(f == {8'h76, v}, "R2 data frame", f, {8'h76, v});
      chk(bq[0] == 24 && bq[1] == 24, "R3 frame length", {bq[0][15:0], bq[1][15:0]}, {16'd24, 16'd24});
    end
    if (gq.size() == 2) begin
      g = gq[1];
      chk(g >= 2 * HALF, "R5 gap between frames", g, 2 * HALF);
    end else chk(0, "R5 gap count", gq.size(), 2);
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1 && sclk === 1 && busy === 0 && done === 0 && aborted === 0,
        "R9 reset state", {cs_n, sclk, busy, done, aborted}, 5'b11000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(cs_n === 1 && busy === 0, "R9 idle after reset", {cs_n, busy}, 2'b10);

    do_write(8'h00, 16'h0000, 0, 0);
    do_write(8'h7F, 16'hFFFF, 0, 0);
    do_write(8'h2A, 16'h5AA5, 0, 0);
    do_write(8'hD5, 16'hA55A, 0, 0);   // R1 bit 7 must be dropped
    do_write(8'h09, 16'h4055, 1, 60);  // R7 start mid-write
    begin
      int idle_ok = 1;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (busy !== 0 || cs_n !== 1) idle_ok = 0;
      end
      chk(idle_ok == 1, "R7 ignored start not queued", idle_ok, 1);
    end

    done_seen = 0;
    @(negedge clk);
    idx = 8'h10; val = 16'h1234; start = 1;
    @(negedge clk);
    start = 0;
    repeat (37) @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(cs_n === 1 && sclk === 1 && busy === 0 && aborted === 1,
        "R8 abort to idle", {cs_n, sclk, busy, aborted}, 4'b1101);
    @(negedge clk);
    chk(aborted === 0, "R8 aborted one cycle", aborted, 0);
    repeat (300) @(negedge clk);
    chk(done_seen == 0, "R8 no done after abort", done_seen, 0);
    do_write(8'h05, 16'hC3E1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule